// File: doc/BRIEF.md
# Four-Source Conditional-Release Interrupt Combiner

This block merges four interrupt sources into one active-low interrupt line. Each source has an enable bit. A source raises a sticky pending flag when its condition goes from low to high while it is enabled. The line goes low while any enabled source has its flag set.

A pending flag is not cleared by reading its status register alone. The read arms the release, and the flag drops only once the source's cause has also gone away. The sources are:

- **Source 0, lookup result.** It covers a finished address lookup whose result words are still unread. A lookup-done pulse loads an internal count of result words. Each read of the result data register uses up one word. The cause is present while any word is left.
- **Source 1, table full.** It follows the lookup table's full flag. A status bit reports the full state, low meaning full.
- **Sources 2 and 3, auxiliary.** Each follows a plain condition input.

Software reads a status register, then removes the cause: it drains the result words or purges a table entry. Only after that does the line release.

Top module: `irq_combiner`

## Requirements
- R1: After synchronous reset, `int_n` is 1 and no source is pending.
- R2: An enabled source whose condition is sampled high at a clock edge, after being low at the previous edge, becomes pending. `int_n` goes low at the following edge.
- R3: A rising condition on a disabled source is ignored. Setting the enable later, while the condition stays high, does not make the source pending.
- R4: Reading a pending source's status register while its condition is still high does not release it. The release happens at the first edge where the condition is low after that read, and `int_n` returns high one edge later.
- R5: A pending source whose condition has gone low stays pending until its status register is read.
- R6: A `lkp_done` pulse loads RES_WORDS result words. Each `rd_stb` with `rd_sel`=1 (result data) uses up one word, down to zero. Source 0's condition is "words left". It is released only by a read with `rd_sel`=0 together with all words consumed, in either order.
- R7: `tbl_room` equals the inverse of `tbl_full`, so 0 means full. Source 1 follows `tbl_full` and is released by a read with `rd_sel`=2 once the table is no longer full.
- R8: Sources 2 and 3 follow `aux_cond[0]` and `aux_cond[1]`. Their status read codes are 3 and 4.
- R9: `int_n` is the registered NOR of the pending flags ANDed with `src_en`. Clearing an enable masks a pending source without discarding it, so setting the enable again reasserts the interrupt.
- R10: A status read while the source is not pending has no effect. It does not pre-arm a later release.
- R11: A read with any other `rd_sel` code does not release a source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| src_en | input | 4 | Per-source enable, bit i for source i |
| lkp_done | input | 1 | One-cycle pulse, lookup result ready |
| tbl_full | input | 1 | Lookup table full flag |
| aux_cond | input | 2 | Conditions of sources 2 and 3 |
| rd_stb | input | 1 | Register read strobe |
| rd_sel | input | 3 | Register being read (codes 0..4) |
| int_n | output | 1 | Interrupt, active low |
| tbl_room | output | 1 | Status bit 0: 1 when the table has room |

## Verification
The bench targets the cases where a status read and the cause disappearing happen in either order:

- A design that clears on the read alone would release while the cause is still there.
- A design that clears on the cause alone would release without any read.
- A design that latches the read while nothing is pending would release a later interrupt with no read at all.

Further cases cover the lookup source with a partial drain, a drain ahead of the status read, and an enable raised after the condition. An enable change that wipes the pending flag, where it should only mask it, is also caught. A cycle model driven by the requirements checks `int_n` on every cycle under random traffic.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;

    localparam int NSRC = 4;
    localparam int NAUX = NSRC - 2;

    typedef enum logic [2:0] {
        SEL_LKP_STAT  = 3'd0,
        SEL_RES_DATA  = 3'd1,
        SEL_SYS_STAT  = 3'd2,
        SEL_AUX0_STAT = 3'd3,
        SEL_AUX1_STAT = 3'd4
    } rd_sel_e;

    typedef struct packed {
        logic pend;
        logic armed;
        logic cond_q;
    } src_state_t;

    function automatic logic [2:0] status_code(input int idx);
        case (idx)
            0:       return SEL_LKP_STAT;
            1:       return SEL_SYS_STAT;
            2:       return SEL_AUX0_STAT;
            default: return SEL_AUX1_STAT;
        endcase
    endfunction

endpackage

// File: rtl/irq_result_count.sv
module irq_result_count
    import irq_comb_pkg::*;
#(
    parameter int RES_WORDS = 4,
    localparam int CW = $clog2(RES_WORDS + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic       rd_i,
    input  logic [2:0] rd_sel_i,
    output logic       left_o
);

    logic [CW-1:0] cnt_q;
    logic          take;

    assign take   = rd_i && (rd_sel_i == SEL_RES_DATA) && (cnt_q != '0);
    assign left_o = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (load_i) cnt_q <= CW'(RES_WORDS);
        else if (take)   cnt_q <= cnt_q - 1'b1;
    end

    // R6: a lookup-done pulse leaves the full word count
    assert_load_R6: assert property (@(posedge clk) disable iff (rst)
        load_i |=> cnt_q == CW'(RES_WORDS));
    // R6: the count never exceeds the loaded amount
    assert_bound_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(RES_WORDS));

endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_comb_pkg::*;
#(
    parameter logic [2:0] CLR_CODE = 3'd0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cond_i,
    input  logic       en_i,
    input  logic       rd_i,
    input  logic [2:0] rd_sel_i,
    output logic       pend_o
);

    src_state_t st, st_n;
    logic       hit, rise, clr;

    assign hit  = rd_i && (rd_sel_i == CLR_CODE);
    assign rise = en_i && cond_i && !st.cond_q;
    assign clr  = st.pend && (st.armed || hit) && !cond_i;

    always_comb begin
        st_n        = st;
        st_n.cond_q = cond_i;
        if (rise) begin
            st_n.pend  = 1'b1;
            st_n.armed = st.pend ? (st.armed || hit) : 1'b0;
        end else if (clr) begin
            st_n.pend  = 1'b0;
            st_n.armed = 1'b0;
        end else begin
            st_n.armed = st.pend && (st.armed || hit);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_n;
    end

    assign pend_o = st.pend;

    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
        (en_i && cond_i && !st.cond_q) |=> st.pend);
    assert_noset_R3: assert property (@(posedge clk) disable iff (rst)
        (!st.pend && !(en_i && cond_i && !st.cond_q)) |=> !st.pend);
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (st.pend && cond_i) |=> st.pend);
    assert_need_read_R5: assert property (@(posedge clk) disable iff (rst)
        (st.pend && !st.armed && !hit) |=> st.pend);
    assert_unarmed_R10: assert property (@(posedge clk) disable iff (rst)
        !st.pend |-> !st.armed);

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
    import irq_comb_pkg::*;
#(
    parameter int RES_WORDS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] src_en,
    input  logic       lkp_done,
    input  logic       tbl_full,
    input  logic [1:0] aux_cond,
    input  logic       rd_stb,
    input  logic [2:0] rd_sel,
    output logic       int_n,
    output logic       tbl_room
);

    logic [NSRC-1:0] cond;
    logic [NSRC-1:0] pend;
    logic            res_left;

    irq_result_count #(.RES_WORDS(RES_WORDS)) u_cnt (
        .clk(clk), .rst(rst), .load_i(lkp_done),
        .rd_i(rd_stb), .rd_sel_i(rd_sel), .left_o(res_left)
    );

    assign cond[0] = res_left;
    assign cond[1] = tbl_full;
    assign cond[NSRC-1:2] = aux_cond[NAUX-1:0];

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        irq_src_cell #(.CLR_CODE(status_code(i))) u_cell (
            .clk(clk), .rst(rst), .cond_i(cond[i]), .en_i(src_en[i]),
            .rd_i(rd_stb), .rd_sel_i(rd_sel), .pend_o(pend[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) int_n <= 1'b1;
        else     int_n <= ~|(pend & src_en);
    end

    assign tbl_room = ~tbl_full;

    assert_nor_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> int_n == ~|$past(pend & src_en));
    assert_rst_R1: assert property (@(posedge clk)
        rst |=> int_n);

endmodule

// File: tb/tb_irq_combiner.sv
module tb_irq_combiner;

    localparam int W = 4;

    logic       clk = 0, rst = 1;
    logic [3:0] src_en = 0;
    logic       lkp_done = 0, tbl_full = 0, rd_stb = 0;
    logic [1:0] aux_cond = 0;
    logic [2:0] rd_sel = 0;
    logic       int_n, tbl_room;

    int total = 0, bad = 0;

    irq_combiner #(.RES_WORDS(W)) dut (
        .clk(clk), .rst(rst), .src_en(src_en), .lkp_done(lkp_done),
        .tbl_full(tbl_full), .aux_cond(aux_cond), .rd_stb(rd_stb),
        .rd_sel(rd_sel), .int_n(int_n), .tbl_room(tbl_room)
    );

    always #4 clk = ~clk;

    // cycle model built from the requirements
    int         m_cnt = 0;
    logic [3:0] mp = 0, ma = 0, mq = 0;
    logic       m_int = 1;

    function automatic logic [2:0] code_of(input int i);
        return (i == 0) ? 3'd0 : (i == 1) ? 3'd2 : (i == 2) ? 3'd3 : 3'd4;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; mp = 0; ma = 0; mq = 0; m_int = 1;
        end else begin
            logic [3:0] c, np, na;
            m_int = ~|(mp & src_en);
            c = {aux_cond, tbl_full, (m_cnt != 0)};
            for (int i = 0; i < 4; i++) begin
                logic hit, rise, clr;
                hit  = rd_stb && rd_sel == code_of(i);
                rise = src_en[i] && c[i] && !mq[i];
                clr  = mp[i] && (ma[i] || hit) && !c[i];
                np[i] = rise ? 1'b1 : clr ? 1'b0 : mp[i];
                na[i] = (clr || (rise && !mp[i])) ? 1'b0 : (mp[i] && (ma[i] || hit));
            end
            mp = np; ma = na; mq = c;
            if (lkp_done) m_cnt = W;
            else if (rd_stb && rd_sel == 3'd1 && m_cnt > 0) m_cnt--;
        end
    end

    task automatic check(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (!rst) begin
        check(int_n, m_int, "R9 model");
        check(tbl_room, ~tbl_full, "R7 status bit0");
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] s);
        rd_stb = 1; rd_sel = s; tick(1); rd_stb = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3); rst = 0; tick(1);
        check(int_n, 1'b1, "R1 reset");
        src_en = 4'hF;
        // R2 / R4 / R8: source 2 (code 3)
        aux_cond[0] = 1; tick(2);
        check(int_n, 1'b0, "R2 assert");
        rd(3'd3); tick(3);
        check(int_n, 1'b0, "R4 read with cause");
        aux_cond[0] = 0; tick(3);
        check(int_n, 1'b1, "R4 release");
        // R5 / R8: source 3 (code 4)
        aux_cond[1] = 1; tick(3); aux_cond[1] = 0; tick(4);
        check(int_n, 1'b0, "R5 no read");
        rd(3'd4); tick(2);
        check(int_n, 1'b1, "R8 code 4 release");
        // R3
        src_en[2] = 0; aux_cond[0] = 1; tick(3);
        check(int_n, 1'b1, "R3 disabled");
        src_en[2] = 1; tick(3);
        check(int_n, 1'b1, "R3 late enable");
        aux_cond[0] = 0; tick(2);
        // R6: status first, then drain
        lkp_done = 1; tick(1); lkp_done = 0; tick(3);
        check(int_n, 1'b0, "R6 result ready");
        rd(3'd0); tick(2);
        for (int k = 0; k < W - 1; k++) rd(3'd1);
        tick(3);
        check(int_n, 1'b0, "R6 partial drain");
        rd(3'd1); tick(3);
        check(int_n, 1'b1, "R6 drained");
        // R6: drain first, then status
        lkp_done = 1; tick(1); lkp_done = 0;
        for (int k = 0; k < W; k++) rd(3'd1);
        tick(3);
        check(int_n, 1'b0, "R6 drain without status");
        rd(3'd0); tick(2);
        check(int_n, 1'b1, "R6 status after drain");
        // R7
        tbl_full = 1; tick(3);
        check(tbl_room, 1'b0, "R7 full bit");
        check(int_n, 1'b0, "R7 full irq");
        rd(3'd2); tick(3);
        check(int_n, 1'b0, "R7 still full");
        tbl_full = 0; tick(3);
        check(int_n, 1'b1, "R7 released");
        // R10: read before pending does not pre-arm
        rd(3'd2); tick(1);
        tbl_full = 1; tick(2); tbl_full = 0; tick(3);
        check(int_n, 1'b0, "R10 no pre-arm");
        rd(3'd2); tick(2);
        check(int_n, 1'b1, "R10 normal release");
        // R11: other codes do not release
        aux_cond[0] = 1; tick(2); aux_cond[0] = 0;
        rd(3'd4); rd(3'd2); rd(3'd0); rd(3'd1); tick(3);
        check(int_n, 1'b0, "R11 wrong code");
        rd(3'd3); tick(2);
        check(int_n, 1'b1, "R11 right code");
        // R9: masking keeps pending
        aux_cond[1] = 1; tick(3);
        src_en[3] = 0; tick(3);
        check(int_n, 1'b1, "R9 masked");
        src_en[3] = 1; tick(2);
        check(int_n, 1'b0, "R9 unmasked");
        aux_cond[1] = 0; rd(3'd4); tick(3);
        // random traffic checked by the model
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 15) == 0) src_en = 4'($urandom);
            if ($urandom_range(0, 9) == 0) aux_cond = 2'($urandom);
            if ($urandom_range(0, 11) == 0) tbl_full = ~tbl_full;
            lkp_done = ($urandom_range(0, 19) == 0);
            rd_stb   = ($urandom_range(0, 2) == 0);
            rd_sel   = 3'($urandom_range(0, 4));
            tick(1);
        end
        lkp_done = 0; rd_stb = 0; tick(2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule